// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Redundancy Correction

This block is the digital back end of a pipelined analog-to-digital converter made of four coarse stages and one final flash stage. Each coarse stage delivers a 3-bit code and the final stage delivers a 4-bit code, once per clock. The codes for one analog sample do not arrive together. Stage k presents its code k clocks after stage 0 does, and the flash code follows four clocks after stage 0.

The block delays every coarse code by enough registers that all five codes of one sample meet in the same cycle. It then forms the output word by shift-and-add. Adjacent stages overlap by one bit because each stage's residue is amplified by four, so the extra bit of each stage folds a comparator error into the next stage's field. The block does not simply concatenate the codes.

A result that overflows the word saturates at full scale. Each code has a valid flag that travels with it. The block accepts a new sample on every clock and produces one corrected word on every clock.

Top module: `adc_pipe_align`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0. The reset is asynchronous.
- R2: For a sample, stage k's code is sampled at clock edge T+k for k = 0..3, and the flash code is sampled at edge T+4. The corrected word and its valid flag appear on the outputs right after edge T+4, which is four clocks after stage 0.
- R3: The word is code0·512 + code1·128 + code2·32 + code3·8 + flash. Stage k's code is stage_code_i[3k+2:3k], so stage 0 has the highest weight and each later stage is shifted two bits less.
- R4: A sum above 4095 gives data_o = 4095. A sum of exactly 4095 passes unchanged.
- R5: valid_o is 1 only when all five valid flags for that sample were 1, each at its own sampling edge. Here stage_valid_i[k] belongs to stage k and flash_valid_i belongs to the flash code.
- R6: When a sample's result is not valid, data_o keeps the last valid word.
- R7: Samples can arrive on consecutive clocks, and each one yields its own word on consecutive clocks with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stage_code_i | input | 12 | Coarse stage codes, stage k in bits [3k+2:3k] |
| stage_valid_i | input | 4 | Per-stage code valid |
| flash_code_i | input | 4 | Final flash stage code |
| flash_valid_i | input | 1 | Flash code valid |
| data_o | output | 12 | Corrected, saturated output word |
| valid_o | output | 1 | Output word valid |

## Verification
The bench skews its stimulus exactly as the stages would, so a wrong delay for any stage mixes codes from neighbouring samples and gives visibly wrong words. It probes the saturation edge with a sum of exactly 4095 and one of exactly 4096. A comparison against the wrong bound, or a clamp that is missing, shows up as 4095 turning into something else or 4096 wrapping to 0. Samples with one missing stage flag and with a missing flash flag check that valid is gated by all five flags. The same samples check that the output holds its value rather than loading the partial sum. A code-weight pattern with a carry through the redundant bits catches a wrong shift or a concatenation in place of addition.

// File: rtl/adc_pipe_pkg.sv
package adc_pipe_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STAGE_BITS = 3;
  localparam int FLASH_BITS = 4;
  localparam int STEP_BITS  = STAGE_BITS - 1;
  localparam int OUT_BITS   = FLASH_BITS + NUM_STAGES * STEP_BITS;
endpackage

// File: rtl/adc_delay_line.sv
module adc_delay_line #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  if (DEPTH == 0) begin : g_bypass
    assign data_o  = data_i;
    assign valid_o = valid_i;
  end else begin : g_regs
    logic [WIDTH:0] tap_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
      end else begin
        tap_q[0] <= {valid_i, data_i};
        for (int i = 1; i < DEPTH; i++) tap_q[i] <= tap_q[i-1];
      end
    end

    assign {valid_o, data_o} = tap_q[DEPTH-1];

    // R5: a valid code leaves exactly DEPTH clocks after it entered valid
    a_r5_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(valid_i, DEPTH));
  end
endmodule

// File: rtl/adc_corr_combine.sv
module adc_corr_combine #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_BITS = 3,
  parameter int FLASH_BITS = 4,
  parameter int OUT_BITS   = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_STAGES*STAGE_BITS-1:0] stage_code_i,
  input  logic [FLASH_BITS-1:0]            flash_code_i,
  input  logic                             valid_i,
  output logic [OUT_BITS-1:0]              data_o,
  output logic                             valid_o
);
  localparam int STEP_BITS = STAGE_BITS - 1;
  localparam int SUM_BITS  = OUT_BITS + 2;

  logic [SUM_BITS-1:0] sum_w;
  logic                ovf_w;
  logic [OUT_BITS-1:0] sat_w;

  always_comb begin
    sum_w = SUM_BITS'(flash_code_i);
    for (int k = 0; k < NUM_STAGES; k++) begin
      sum_w = sum_w + (SUM_BITS'(stage_code_i[k*STAGE_BITS +: STAGE_BITS])
                       << (FLASH_BITS - 1 + STEP_BITS * (NUM_STAGES - 1 - k)));
    end
  end

  assign ovf_w = |sum_w[SUM_BITS-1:OUT_BITS];
  assign sat_w = ovf_w ? '1 : sum_w[OUT_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat_w;
    end
  end

  // R4: an overflowing sum saturates at full scale
  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sum_w >= SUM_BITS'(1 << OUT_BITS)) |=> (data_o == '1));
  // R3: an in-range sum is passed unchanged
  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sum_w < SUM_BITS'(1 << OUT_BITS)) |=> (data_o == $past(sum_w[OUT_BITS-1:0])));
  // R6: word held when the sample is not valid
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/adc_pipe_align.sv
module adc_pipe_align #(
  parameter int NUM_STAGES = adc_pipe_pkg::NUM_STAGES,
  parameter int STAGE_BITS = adc_pipe_pkg::STAGE_BITS,
  parameter int FLASH_BITS = adc_pipe_pkg::FLASH_BITS,
  parameter int OUT_BITS   = adc_pipe_pkg::OUT_BITS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_STAGES*STAGE_BITS-1:0] stage_code_i,
  input  logic [NUM_STAGES-1:0]            stage_valid_i,
  input  logic [FLASH_BITS-1:0]            flash_code_i,
  input  logic                             flash_valid_i,
  output logic [OUT_BITS-1:0]              data_o,
  output logic                             valid_o
);
  logic [NUM_STAGES*STAGE_BITS-1:0] aligned_code;
  logic [NUM_STAGES-1:0]            aligned_valid;
  logic                             all_valid;

  // R2: stage k waits NUM_STAGES-k clocks to meet the flash code
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    adc_delay_line #(
      .WIDTH(STAGE_BITS),
      .DEPTH(NUM_STAGES - k)
    ) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (stage_code_i[k*STAGE_BITS +: STAGE_BITS]),
      .valid_i(stage_valid_i[k]),
      .data_o (aligned_code[k*STAGE_BITS +: STAGE_BITS]),
      .valid_o(aligned_valid[k])
    );
  end

  assign all_valid = (&aligned_valid) & flash_valid_i;

  adc_corr_combine #(
    .NUM_STAGES(NUM_STAGES),
    .STAGE_BITS(STAGE_BITS),
    .FLASH_BITS(FLASH_BITS),
    .OUT_BITS  (OUT_BITS)
  ) u_comb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stage_code_i(aligned_code),
    .flash_code_i(flash_code_i),
    .valid_i     (all_valid),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );

  // R5: output valid requires the flash flag one clock earlier
  a_r5_flash_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(flash_valid_i));
  // R5: and the first stage's flag at the start of the sample
  a_r5_first_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(stage_valid_i[0], NUM_STAGES + 1));
endmodule

// File: tb/adc_pipe_align_tb.sv
module adc_pipe_align_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [2:0]  s0, s1, s2, s3;
    logic [3:0]  fl;
    logic [4:0]  vmask; // bit k = stage k valid, bit 4 = flash valid
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 3'd0, 3'd0, 4'd0,  5'b11111, 12'd0},
    '{3'd4, 3'd0, 3'd0, 3'd0, 4'd0,  5'b11111, 12'd2048},
    '{3'd1, 3'd2, 3'd3, 3'd4, 4'd5,  5'b11111, 12'd901},
    '{3'd7, 3'd7, 3'd7, 3'd7, 4'd15, 5'b11111, 12'd4095},
    '{3'd3, 3'd7, 3'd0, 3'd1, 4'd8,  5'b11111, 12'd2448},
    '{3'd7, 3'd0, 3'd7, 3'd7, 4'd15, 5'b11111, 12'd3879},
    '{3'd6, 3'd3, 3'd3, 3'd3, 4'd7,  5'b11011, 12'd0},
    '{3'd7, 3'd3, 3'd3, 3'd3, 4'd7,  5'b11111, 12'd4095},
    '{3'd7, 3'd4, 3'd0, 3'd0, 4'd0,  5'b11111, 12'd4095},
    '{3'd2, 3'd5, 3'd1, 3'd6, 4'd9,  5'b11111, 12'd1753},
    '{3'd1, 3'd1, 3'd1, 3'd1, 4'd1,  5'b01111, 12'd0},
    '{3'd0, 3'd0, 3'd0, 3'd0, 4'd1,  5'b11111, 12'd1},
    '{3'd7, 3'd7, 3'd6, 3'd6, 4'd15, 5'b11111, 12'd4095}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] stage_code_i = '0;
  logic [3:0]  stage_valid_i = '0;
  logic [3:0]  flash_code_i = '0;
  logic        flash_valid_i = 1'b0;
  logic [11:0] data_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  adc_pipe_align u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stage_code_i(stage_code_i), .stage_valid_i(stage_valid_i),
    .flash_code_i(flash_code_i), .flash_valid_i(flash_valid_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(vec_t v, int k);
    case (k)
      0: return v.s0;
      1: return v.s1;
      2: return v.s2;
      default: return v.s3;
    endcase
  endfunction

  initial begin
    int last_exp;
    repeat (3) @(negedge clk_i);
    check_eq("R1 valid_o in reset", int'(valid_o), 0);
    check_eq("R1 data_o in reset", int'(data_o), 0);
    rst_ni = 1'b1;
    last_exp = 0;

    // skewed table walk: stage k gets sample c-k, flash gets sample c-4
    for (int c = 0; c < NV + 6; c++) begin
      @(negedge clk_i);
      if (c >= 5 && c - 5 < NV) begin
        automatic int j = c - 5;
        automatic bit ok = (VECS[j].vmask == 5'b11111);
        if (ok) last_exp = int'(VECS[j].exp);
        check_eq($sformatf("R2/R5 valid_o sample %0d", j), int'(valid_o), int'(ok));
        check_eq($sformatf("R3/R4/R6/R7 data_o sample %0d", j), int'(data_o), last_exp);
      end
      for (int k = 0; k < 4; k++) begin
        automatic int j = c - k;
        if (j >= 0 && j < NV) begin
          stage_code_i[k*3 +: 3] = code_of(VECS[j], k);
          stage_valid_i[k] = VECS[j].vmask[k];
        end else begin
          stage_code_i[k*3 +: 3] = '0;
          stage_valid_i[k] = 1'b0;
        end
      end
      if (c - 4 >= 0 && c - 4 < NV) begin
        flash_code_i = VECS[c-4].fl;
        flash_valid_i = VECS[c-4].vmask[4];
      end else begin
        flash_code_i = '0;
        flash_valid_i = 1'b0;
      end
    end

    // R7: steady stream of identical samples gives a word every clock
    stage_code_i = 12'b000_000_000_100;
    stage_valid_i = 4'hF;
    flash_code_i = 4'd3;
    flash_valid_i = 1'b1;
    repeat (6) @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      check_eq("R7 back-to-back valid", int'(valid_o), 1);
      check_eq("R7 back-to-back data", int'(data_o), 2051);
      @(negedge clk_i);
    end

    // R1: asynchronous reset clears outputs without a clock edge
    #1 rst_ni = 1'b0;
    #1;
    check_eq("R1 async valid_o", int'(valid_o), 0);
    check_eq("R1 async data_o", int'(data_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule